// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Transmitter

This block turns bytes handed over by a host into asynchronous serial frames on a single output line. It runs directly from a clock at sixteen times the bit rate (the oversampling factor is a parameter), so every clock cycle is one sub-bit tick. A frame is a low start bit, then 5 to 8 data bits least significant first, then an optional parity bit, then a high stop period of one, one and a half, or two bit times.

The host writes through a level strobe. While the strobe is high, the block samples the data. When the strobe falls, the data goes into a one-entry holding register and a one-cycle completion pulse is raised. The frame engine takes the holding register as soon as it is idle and latches the line configuration at that moment. Software can therefore rewrite the configuration inputs while a frame is on the wire. Two status flags report on the transmit path. One shows that the holding register can take another byte. The other shows that both the holding register and the shifter are empty. A break input pulls the line low for as long as it is held.

Top module: `uart_serial_tx`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1, `tx_empty` is 1 and `wr_done` is 0.
- R2: On the first clock edge at which `wr_en` is sampled 0 after being sampled 1, the holding register takes the `wr_data` value sampled at the last edge where `wr_en` was 1. `hold_empty` drops to 0 and `wr_done` is 1 for exactly one cycle.
- R3: At the next clock edge at which the frame engine is idle and `hold_empty` is 0, the byte moves into the shifter and `hold_empty` returns to 1. From that same edge, `txd` carries the start bit (0).
- R4: The start bit, each data bit and the parity bit each last OVERSAMPLE (16) cycles. Data bits are sent least significant bit first.
- R5: `len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Unused upper bits of `wr_data` are never sent.
- R6: With `par_en`=1 and `par_stick`=0, a parity bit follows the data. With `par_even`=1 it is the XOR of the sent data bits (even parity). With `par_even`=0 it is that XOR inverted (odd parity). With `par_en`=0 no parity bit is sent.
- R7: With `par_en`=1 and `par_stick`=1, the parity bit is the inverse of `par_even`, whatever the data.
- R8: The stop period is high and lasts as follows. `stop_sel`=0 gives 16 cycles. `stop_sel`=1 gives 24 cycles when `len_sel`=0 and 32 cycles otherwise. `stop_sel`=2 or 3 gives 32 cycles.
- R9: `tx_empty` is 1 only when `hold_empty` is 1 and no frame is in progress. It rises the cycle after the last stop cycle.
- R10: While `brk` is 1, `txd` is 0. Break does not alter frame timing: the frame carries on underneath and resumes its expected values when `brk` is released.
- R11: A byte written while a frame is in progress waits in the holding register (`hold_empty`=0). After the current stop period, the line stays high for one cycle and then the next start bit begins.
- R12: `len_sel`, `stop_sel`, `par_en`, `par_even` and `par_stick` are sampled only when a byte is moved into the shifter. Changes during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at OVERSAMPLE times the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, level; the write completes when it falls |
| wr_data | input | 8 | Byte to transmit, sampled while `wr_en` is high |
| len_sel | input | 2 | Data length code: 0..3 gives 5..8 bits |
| stop_sel | input | 2 | Stop length code: 0 one, 1 one and a half (5-bit only), 2/3 two |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 selects even parity, 0 odd |
| par_stick | input | 1 | Fixed parity bit equal to the inverse of `par_even` |
| brk | input | 1 | Forces `txd` low while high |
| txd | output | 1 | Serial output line, idles high |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and shifter both empty |
| wr_done | output | 1 | One-cycle pulse at completion of a host write |

## Verification
The hardest situations to reach from the ports are those where two activities overlap: a second write landing while a frame is on the wire, and configuration or break changes partway through a frame. The bench reaches them by driving the write strobe, the configuration inputs and `brk` from inside its per-cycle frame checker, at fixed tick offsets. It also sweeps every combination of length, parity mode and stop code, and checks every tick of each frame against a waveform it computes itself. That sweep covers the 24-cycle stop period, which only appears with 5-bit characters, and the fall-back to two stop bits for longer characters.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   localparam int unsigned TX_MIN_BITS = 5;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_START,
      TX_DATA,
      TX_PAR,
      TX_STOP
   } tx_state_e;

   typedef struct packed {
      logic [1:0] stop;
      logic       par_en;
      logic       par_even;
      logic       par_stick;
   } tx_frame_cfg_t;

endpackage

// File: rtl/tx_host_port.sv
module tx_host_port #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load_ack,
   output logic [DATA_W-1:0] hold_q,
   output logic              hold_empty,
   output logic              wr_done
);

   logic              wr_en_q;
   logic [DATA_W-1:0] data_q;
   logic              commit;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("tx_host_port: DATA_W must be at least 1");
      end
   endgenerate

   assign commit = wr_en_q & ~wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_q    <= 1'b0;
         data_q     <= '0;
         hold_q     <= '0;
         hold_empty <= 1'b1;
         wr_done    <= 1'b0;
      end else begin
         wr_en_q <= wr_en;
         wr_done <= commit;
         if (wr_en) begin
            data_q <= wr_data;
         end
         if (commit) begin
            hold_q     <= data_q;
            hold_empty <= 1'b0;
         end else if (load_ack) begin
            hold_empty <= 1'b1;
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);  // R2
   AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> !hold_empty);  // R2

endmodule

// File: rtl/tx_parity_gen.sv
module tx_parity_gen
   import uart_tx_pkg::*;
#(
   parameter int unsigned LEN_W  = 2,
   parameter int unsigned DATA_W = TX_MIN_BITS + (1 << LEN_W) - 1
) (
   input  logic [DATA_W-1:0] data,
   input  logic [LEN_W-1:0]  len,
   input  tx_frame_cfg_t     cfg,
   output logic              pbit
);

   logic [DATA_W-1:0] used;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         if (i < TX_MIN_BITS) begin : g_always
            assign used[i] = data[i];
         end else begin : g_optional
            assign used[i] = data[i] & (len >= LEN_W'(i - TX_MIN_BITS + 1));
         end
      end
   endgenerate

   assign pbit = cfg.par_stick ? ~cfg.par_even : ((^used) ^ ~cfg.par_even);

endmodule

// File: rtl/tx_frame_engine.sv
module tx_frame_engine
   import uart_tx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned LEN_W      = 2,
   parameter int unsigned DATA_W     = TX_MIN_BITS + (1 << LEN_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_empty,
   input  logic [DATA_W-1:0] hold_data,
   input  logic [LEN_W-1:0]  len_in,
   input  tx_frame_cfg_t     cfg_in,
   output logic              load_ack,
   output logic              busy,
   output logic              line
);

   localparam int unsigned CNT_W = $clog2(2 * OVERSAMPLE);
   localparam int unsigned IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVERSAMPLE - 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] TWO_LAST  = CNT_W'(2 * OVERSAMPLE - 1);

   generate
      if (OVERSAMPLE < 2 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("tx_frame_engine: OVERSAMPLE must be even and at least 2");
      end
      if (LEN_W < 1 || LEN_W > 3) begin : g_bad_len
         $error("tx_frame_engine: LEN_W must be 1 to 3");
      end
   endgenerate

   tx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  bit_idx;
   logic [DATA_W-1:0] shreg;
   logic [LEN_W-1:0]  len_q;
   tx_frame_cfg_t     cfg_q;
   logic              pbit_q;
   logic              pbit_new;
   logic [CNT_W-1:0]  slot_last;
   logic [IDX_W-1:0]  data_last;

   tx_parity_gen #(
      .LEN_W  (LEN_W),
      .DATA_W (DATA_W)
   ) u_parity (
      .data (hold_data),
      .len  (len_in),
      .cfg  (cfg_in),
      .pbit (pbit_new)
   );

   assign data_last = IDX_W'(TX_MIN_BITS - 1) + IDX_W'(len_q);

   always_comb begin
      slot_last = BIT_LAST;
      if (state == TX_STOP) begin
         unique case (cfg_q.stop)
            2'b00:   slot_last = BIT_LAST;
            2'b01:   slot_last = (len_q == '0) ? HALF_LAST : TWO_LAST;
            default: slot_last = TWO_LAST;
         endcase
      end
   end

   assign load_ack = (state == TX_IDLE) && !hold_empty;
   assign busy     = (state != TX_IDLE);

   always_comb begin
      unique case (state)
         TX_START: line = 1'b0;
         TX_DATA:  line = shreg[0];
         TX_PAR:   line = pbit_q;
         default:  line = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= TX_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         len_q   <= '0;
         cfg_q   <= '0;
         pbit_q  <= 1'b0;
      end else if (state == TX_IDLE) begin
         cnt     <= '0;
         bit_idx <= '0;
         if (!hold_empty) begin
            shreg  <= hold_data;
            len_q  <= len_in;
            cfg_q  <= cfg_in;
            pbit_q <= pbit_new;
            state  <= TX_START;
         end
      end else if (cnt != slot_last) begin
         cnt <= cnt + 1'b1;
      end else begin
         cnt <= '0;
         unique case (state)
            TX_START: state <= TX_DATA;
            TX_DATA: begin
               shreg   <= shreg >> 1;
               bit_idx <= bit_idx + 1'b1;
               if (bit_idx == data_last) begin
                  state <= cfg_q.par_en ? TX_PAR : TX_STOP;
               end
            end
            TX_PAR:  state <= TX_STOP;
            default: state <= TX_IDLE;
         endcase
      end
   end

   AST_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> $stable(line));  // R4
   AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TX_IDLE) |-> (cnt == '0));  // R3

endmodule

// File: rtl/uart_serial_tx.sv
module uart_serial_tx
   import uart_tx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned LEN_W      = 2,
   parameter int unsigned DATA_W     = TX_MIN_BITS + (1 << LEN_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LEN_W-1:0]  len_sel,
   input  logic [1:0]        stop_sel,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              par_stick,
   input  logic              brk,
   output logic              txd,
   output logic              hold_empty,
   output logic              tx_empty,
   output logic              wr_done
);

   generate
      if (DATA_W != TX_MIN_BITS + (1 << LEN_W) - 1) begin : g_bad_data
         $error("uart_serial_tx: DATA_W must match the longest length code");
      end
   endgenerate

   logic [DATA_W-1:0] hold_q;
   logic              load_ack;
   logic              busy;
   logic              line;
   tx_frame_cfg_t     cfg;

   assign cfg = '{stop: stop_sel, par_en: par_en, par_even: par_even, par_stick: par_stick};

   tx_host_port #(
      .DATA_W (DATA_W)
   ) u_host (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .load_ack   (load_ack),
      .hold_q     (hold_q),
      .hold_empty (hold_empty),
      .wr_done    (wr_done)
   );

   tx_frame_engine #(
      .OVERSAMPLE (OVERSAMPLE),
      .LEN_W      (LEN_W),
      .DATA_W     (DATA_W)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_empty (hold_empty),
      .hold_data  (hold_q),
      .len_in     (len_sel),
      .cfg_in     (cfg),
      .load_ack   (load_ack),
      .busy       (busy),
      .line       (line)
   );

   assign txd      = line & ~brk;
   assign tx_empty = hold_empty & ~busy;

   AST_LOAD_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(!hold_empty));  // R3
   AST_STOP_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(txd || brk));  // R8

endmodule

// File: tb/uart_serial_tx_bench.sv
module uart_serial_tx_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic [7:0] wr_data;
   logic [1:0] len_sel;
   logic [1:0] stop_sel;
   logic       par_en, par_even, par_stick, brk;
   logic       txd, hold_empty, tx_empty, wr_done;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   uart_serial_tx u_uart_serial_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .len_sel    (len_sel),
      .stop_sel   (stop_sel),
      .par_en     (par_en),
      .par_even   (par_even),
      .par_stick  (par_stick),
      .brk        (brk),
      .txd        (txd),
      .hold_empty (hold_empty),
      .tx_empty   (tx_empty),
      .wr_done    (wr_done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int stop_ticks(input logic [1:0] l, input logic [1:0] s);
      if (s == 2'd0) return 16;
      if (s == 2'd1) return (l == 2'd0) ? 24 : 32;
      return 32;
   endfunction

   function automatic logic exp_line(input int i, input logic [7:0] b, input int n,
                                     input logic pe, input logic pb);
      int slot = i / 16;
      if (slot == 0) return 1'b0;
      if (slot <= n) return b[slot-1];
      if (pe && slot == n + 1) return pb;
      return 1'b1;
   endfunction

   task automatic set_cfg(input int l, input int pm, input int s);
      len_sel   = 2'(l);
      stop_sel  = 2'(s);
      par_en    = (pm != 0);
      par_even  = (pm == 1) || (pm == 3);
      par_stick = (pm >= 3);
   endtask

   // Host write; commit edge follows, load happens at the edge after the check.
   task automatic do_write(input logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = 8'h00;
      @(negedge clk);
      #1;
      chk(wr_done === 1'b1 && hold_empty === 1'b0, "R2 done/hold", {wr_done, hold_empty}, 2);
   endtask

   task automatic frame(input logic [7:0] b, input int bk0, input int bk1, input bit chg,
                        input bit b2b, input logic [7:0] b2, input string tag);
      logic [1:0] l  = len_sel;
      logic [1:0] s  = stop_sel;
      logic       pe = par_en;
      logic       ev = par_even;
      logic       st = par_stick;
      int   n  = 5 + int'(l);
      logic [7:0] mask = 8'((1 << n) - 1);
      logic pb = st ? ~ev : ((^(b & mask)) ^ ~ev);
      int   ft = 16 * (1 + n + (pe ? 1 : 0)) + stop_ticks(l, s);
      int   bad = 0;
      int   bi = 0;
      int   ba = 0;
      int   be = 0;
      for (int i = 0; i < ft; i++) begin
         logic e;
         @(negedge clk);
         brk = (i >= bk0 && i < bk1);
         #1;
         e = brk ? 1'b0 : exp_line(i, b, n, pe, pb);
         if (i == 0) chk(hold_empty === 1'b1, "R3 hold empty after load", hold_empty, 1);
         if (txd !== e || tx_empty !== 1'b0) begin
            if (bad == 0) begin
               bi = i;
               ba = {tx_empty, txd};
               be = {1'b0, e};
            end
            bad++;
         end
         if (chg && i == 40) begin
            len_sel = ~l;
            stop_sel = ~s;
            par_en = ~pe;
            par_even = ~ev;
            par_stick = ~st;
         end
         if (b2b) begin
            if (i == 2) begin
               wr_en = 1'b1;
               wr_data = b2;
            end
            if (i == 3) wr_en = 1'b0;
            if (i == 4) chk(wr_done === 1'b1 && hold_empty === 1'b0, "R11 queued write",
                            {wr_done, hold_empty}, 2);
         end
      end
      brk = 1'b0;
      if (chg) begin
         len_sel = l;
         stop_sel = s;
         par_en = pe;
         par_even = ev;
         par_stick = st;
      end
      if (bad != 0) $display("  first mismatch at tick %0d of frame %02h", bi, b);
      chk(bad == 0, tag, ba, be);
      @(negedge clk);
      #1;
      if (b2b)
         chk(txd === 1'b1 && tx_empty === 1'b0 && hold_empty === 1'b0, "R11 idle gap",
             {txd, tx_empty, hold_empty}, 4);
      else
         chk(txd === 1'b1 && tx_empty === 1'b1 && hold_empty === 1'b1, "R9 empty after stop",
             {txd, tx_empty, hold_empty}, 7);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      wr_en = 1'b0;
      wr_data = 8'h00;
      brk = 1'b0;
      set_cfg(3, 0, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1 reset state
      chk(txd === 1'b1 && hold_empty === 1'b1 && tx_empty === 1'b1 && wr_done === 1'b0,
          "R1 reset state", {txd, hold_empty, tx_empty, wr_done}, 14);

      // R10 break while idle
      @(negedge clk);
      brk = 1'b1;
      #1;
      chk(txd === 1'b0, "R10 break idle", txd, 0);
      @(negedge clk);
      brk = 1'b0;
      #1;
      chk(txd === 1'b1, "R10 release idle", txd, 1);

      // R4 R5 R6 R7 R8: every length, parity mode and stop code
      for (int l = 0; l < 4; l++)
         for (int pm = 0; pm < 5; pm++)
            for (int s = 0; s < 4; s++) begin
               logic [7:0] b = 8'((l * 37 + pm * 11 + s * 71 + 90) & 255);
               set_cfg(l, pm, s);
               do_write(b);
               frame(b, 0, 0, 1'b0, 1'b0, 8'h00, "R4 R5 R6 R7 R8 frame sweep");
            end

      // R6 every byte value, 8 bits, odd parity, 1 stop
      set_cfg(3, 2, 0);
      for (int v = 0; v < 256; v++) begin
         do_write(8'(v));
         frame(8'(v), 0, 0, 1'b0, 1'b0, 8'h00, "R4 R6 byte sweep");
      end

      // R10 break in the middle of a frame
      set_cfg(3, 1, 2);
      do_write(8'hC3);
      frame(8'hC3, 20, 45, 1'b0, 1'b0, 8'h00, "R10 break mid-frame");

      // R12 configuration changed mid-frame
      set_cfg(0, 4, 1);
      do_write(8'h96);
      frame(8'h96, 0, 0, 1'b1, 1'b0, 8'h00, "R12 config ignored mid-frame");

      // R11 back-to-back bytes
      set_cfg(2, 1, 0);
      do_write(8'h3C);
      frame(8'h3C, 0, 0, 1'b0, 1'b1, 8'hE1, "R4 first of pair");
      frame(8'hE1, 0, 0, 1'b0, 1'b0, 8'h00, "R11 queued frame");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule